// File: doc/BRIEF.md
# External Memory Pseudo-Random Self-Test Engine

This block exercises an external memory with no processor involvement. One start pulse latches a seed and an inclusive address window, and the engine then loops over passes. Each pass has two phases. The write phase fills the whole window with words from a 32-bit linear feedback shift register. The read phase reloads the register with the same seed, reads the window back and compares every returned word against the regenerated value.

Pass after pass the seed moves forward by one generator step, so each pass puts different data into every location. At the end of every pass the engine publishes a done flag and a sticky fail flag. It also keeps the address of the first miscompare seen since the last start.

The memory side is a plain synchronous port. The engine raises a request with an address, a write flag and write data, and holds them until it samples ready high. Read data comes back a fixed two cycles after an accepted read. A stop pulse ends the run at the next pass boundary.

Top module: `mem_prbs_bist`

## Requirements
- R1: After reset, busy, done, fail and mem_req are low and fail_addr is zero.
- R2: In the write phase, mem_addr runs upward from the latched low address to the latched high address, one step per accepted write. The write data starts at the pass seed and advances one generator step per accepted write. A step maps s to {s[30:0], s[31]^s[21]^s[1]^s[0]}.
- R3: A seed input of zero is replaced by the value 1 when start is sampled.
- R4: After the last write is accepted, reads cover the same window in the same ascending order. The word present on mem_rdata two cycles after each accepted read is compared with the regenerated sequence for that address.
- R5: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr and mem_wdata hold their values into the next cycle.
- R6: Passes repeat with no gap until a stop. The seed of each pass is one generator step past the seed of the previous pass.
- R7: done rises at the end of the first complete pass and stays high until the next start.
- R8: fail changes only at a pass boundary. It goes high at the end of any pass that saw a miscompare and stays high until reset or the next start.
- R9: fail_addr holds the address of the first miscompare since the last start. Later miscompares leave it unchanged.
- R10: A stop pulse lets the current pass finish. The engine then drops busy and issues no further requests, and done and fail keep their values.
- R11: A start pulse during a run abandons that run. In the next cycle done, fail and fail_addr are clear, busy is high, and a new run begins with the new seed and window.
- R12: A window whose low and high addresses are equal gives one-word passes that complete normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: latch seed and window, begin a run |
| stop | input | 1 | Pulse: end the run at the next pass boundary |
| seed_init | input | 32 | Seed for the first pass |
| addr_lo | input | ADDR_W | Lowest address tested (inclusive) |
| addr_hi | input | ADDR_W | Highest address tested (inclusive), not below addr_lo |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid two cycles after an accepted read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | At least one pass has completed since start |
| fail | output | 1 | Sticky miscompare flag, updated at pass ends |
| fail_addr | output | ADDR_W | Address of the first miscompare |

## Verification
The bench builds the engine with ADDR_W = 5, so its 32-word memory model can cover the whole address space in a single pass. That size also keeps windows of one word, of a partial range and of every location short enough to run several back-to-back passes, a stop and a mid-run restart. The model injects a bit flip on reads at two chosen addresses. This shows the fail flag waiting for the pass boundary, staying set on a later clean pass, and fail_addr keeping the lower of the two faulty addresses. Expected write data and seed advance come from the generator step in the requirements, computed in the bench. Ready is tested both held high and stalling one cycle in three.

// File: rtl/mem_prbs_bist.sv
module mem_prbs_bist #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [31:0]       seed_init,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] addr_hi,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_DRAIN} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q, lo_q, hi_q, p0a, p1a;
  logic [31:0]       seed_q, lfsr_q, p0d, p1d;
  logic              p0v, p1v, err_pass, stop_pend;

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  wire acc      = mem_req & mem_ready;
  wire last     = addr_q == hi_q;
  wire mism     = p1v && (mem_rdata != p1d);
  wire pass_end = (st == S_DRAIN) && !p0v && p1v;
  wire [31:0] seed_in = (seed_init == 32'd0) ? 32'd1 : seed_init;

  assign mem_req   = (st == S_WR) || (st == S_RD);
  assign mem_we    = st == S_WR;
  assign mem_addr  = addr_q;
  assign mem_wdata = lfsr_q;
  assign busy      = st != S_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0; lo_q <= '0; hi_q <= '0;
      seed_q <= 32'd1; lfsr_q <= 32'd1;
      p0v <= 1'b0; p1v <= 1'b0;
      p0d <= '0; p1d <= '0; p0a <= '0; p1a <= '0;
      err_pass <= 1'b0; stop_pend <= 1'b0;
      done <= 1'b0; fail <= 1'b0; fail_addr <= '0;
    end else if (start) begin
      st <= S_WR;
      lo_q <= addr_lo; hi_q <= addr_hi; addr_q <= addr_lo;
      seed_q <= seed_in; lfsr_q <= seed_in;
      p0v <= 1'b0; p1v <= 1'b0;
      err_pass <= 1'b0; stop_pend <= 1'b0;
      done <= 1'b0; fail <= 1'b0; fail_addr <= '0;
    end else begin
      p0v <= (st == S_RD) && acc;
      p0d <= lfsr_q;
      p0a <= addr_q;
      p1v <= p0v;
      p1d <= p0d;
      p1a <= p0a;
      if (mism && !fail && !err_pass) fail_addr <= p1a;
      err_pass <= err_pass | mism;
      if (stop && st != S_IDLE) stop_pend <= 1'b1;
      case (st)
        S_WR: if (acc) begin
          if (last) begin
            st <= S_RD;
            addr_q <= lo_q;
            lfsr_q <= seed_q;
          end else begin
            addr_q <= addr_q + 1'b1;
            lfsr_q <= step(lfsr_q);
          end
        end
        S_RD: if (acc) begin
          if (last) st <= S_DRAIN;
          else begin
            addr_q <= addr_q + 1'b1;
            lfsr_q <= step(lfsr_q);
          end
        end
        S_DRAIN: if (pass_end) begin
          done <= 1'b1;
          fail <= fail | err_pass | mism;
          err_pass <= 1'b0;
          if (stop_pend || stop) begin
            st <= S_IDLE;
            stop_pend <= 1'b0;
          end else begin
            st <= S_WR;
            addr_q <= lo_q;
            seed_q <= step(seed_q);
            lfsr_q <= step(seed_q);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module mem_prbs_bist_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] lo,
  input logic [ADDR_W-1:0] hi
);
  a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !start) |=>
      (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  a_r2_addr_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr >= lo && mem_addr <= hi));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !fail && busy));
endmodule

bind mem_prbs_bist mem_prbs_bist_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .busy(busy), .done(done), .fail(fail), .lo(lo_q), .hi(hi_q)
);

// File: tb/mem_prbs_bist_tb.sv
module mem_prbs_bist_tb;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic [31:0] seed_init = '0;
  logic [AW-1:0] addr_lo = '0, addr_hi = '0;
  logic mem_req, mem_we, mem_ready = 1'b0, busy, done, fail;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #4 clk = ~clk;

  mem_prbs_bist #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .seed_init(seed_init),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  logic [31:0] mem [0:31];
  logic [31:0] rp0 = '0, rp1 = '0;
  logic flt_en = 1'b0;
  wire  [31:0] flt = (flt_en && (mem_addr == 5'd9 || mem_addr == 5'd17)) ? 32'h100 : 32'h0;
  assign mem_rdata = rp1;

  always @(posedge clk) begin
    if (mem_req && mem_ready && mem_we) mem[mem_addr] <= mem_wdata;
    rp0 <= mem[mem_addr] ^ flt;
    rp1 <= rp0;
  end

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  int n_chk = 0, n_fail = 0;
  int rmode = 0, rcnt = 0;
  int w_cnt = 0, r_cnt = 0, wr_bad = 0, rd_bad = 0;
  int lo = 0, hi = 0;
  logic [31:0] w_seed, w_dat, first_w;
  int w_addr = 0, r_addr = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    rcnt++;
    mem_ready = (rmode == 0) ? 1'b1 : ((rcnt % 3) != 2);
    #3;
    if (rst_n && !start && mem_req && mem_ready) begin
      if (mem_we) begin
        if (w_cnt == 0) first_w = mem_wdata;
        if (mem_addr !== w_addr[AW-1:0] || mem_wdata !== w_dat) wr_bad++;
        w_cnt++;
        if (w_addr == hi) begin
          w_addr = lo; w_seed = step(w_seed); w_dat = w_seed;
        end else begin
          w_addr++; w_dat = step(w_dat);
        end
      end else begin
        if (mem_addr !== r_addr[AW-1:0]) rd_bad++;
        r_cnt++;
        r_addr = (r_addr == hi) ? lo : r_addr + 1;
      end
    end
  end

  task automatic arm(input logic [31:0] s, input int l, input int h);
    @(negedge clk);
    seed_init = s; addr_lo = l[AW-1:0]; addr_hi = h[AW-1:0];
    lo = l; hi = h; w_addr = l; r_addr = l;
    w_seed = (s == 0) ? 32'd1 : s; w_dat = w_seed;
    w_cnt = 0; r_cnt = 0; wr_bad = 0; rd_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_reads(input int tgt);
    for (int i = 0; i < 50000 && r_cnt < tgt; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic halt();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    for (int i = 0; i < 50000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int wsave;
    repeat (5) @(negedge clk);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 fail", fail, 0); check("R1 mem_req", mem_req, 0);
    check("R1 fail_addr", fail_addr, 0);
    rst_n = 1'b1;

    rmode = 1;
    arm(32'h0000_0001, 3, 12);
    wait_reads(10);
    check("R7 done after first pass", done, 1);
    check("R4 clean pass fail", fail, 0);
    check("R6 still running", busy, 1);
    wait_reads(30);
    check("R2,R6 write stream errors", wr_bad, 0);
    check("R4 read order errors", rd_bad, 0);
    check("R6 passes continue", (w_cnt >= 30), 1);
    halt();
    check("R10 idle after stop", busy, 0);
    check("R10 stop at boundary", ((r_cnt % 10) == 0) && (w_cnt == r_cnt), 1);
    check("R10 done kept", done, 1);
    wsave = w_cnt;
    repeat (10) @(negedge clk);
    check("R10 no requests", mem_req, 0);
    check("R10 no further writes", w_cnt, wsave);

    rmode = 0;
    flt_en = 1'b1;
    arm(32'hDEAD_BEEF, 0, 31);
    wait_reads(20);
    check("R8 fail waits for pass end", fail, 0);
    wait_reads(32);
    flt_en = 1'b0;
    check("R8 fail at pass end", fail, 1);
    check("R9 first failing address", fail_addr, 9);
    wait_reads(64);
    check("R8 fail sticky on clean pass", fail, 1);
    check("R9 address held", fail_addr, 9);
    check("R2,R6 write stream full window", wr_bad, 0);

    rmode = 1;
    arm(32'h0, 7, 7);
    check("R11 done cleared", done, 0);
    check("R11 fail cleared", fail, 0);
    check("R11 fail_addr cleared", fail_addr, 0);
    check("R11 busy", busy, 1);
    wait_reads(3);
    check("R3 zero seed becomes one", first_w, 32'd1);
    check("R12 single word done", done, 1);
    check("R12 single word fail", fail, 0);
    check("R12 single word stream", wr_bad + rd_bad, 0);
    halt();
    check("R10 idle after second stop", busy, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule